// File: doc/BRIEF.md
# Mode-0 Parallel I/O Port

This block is a bus-attached general-purpose parallel I/O peripheral with three ports, named A, B and C, each `PORT_W` bits wide (8 by default). Port C is handled as two independent halves, upper and lower. A host reaches the block over a small synchronous bus: a 2-bit address, a write strobe with write data, and a read strobe whose result appears on a registered read-data output one cycle later.

A single control byte, written to the control address with its top bit set, sets the direction of all four groups (A, B, C-upper, C-lower) in one access. A group set as output drives its latched value onto its output pins with every output enable high. A group set as input drops its output enables, and a read of it returns the live pin values. Only the simple mode is built. The mode-select fields in the control byte are accepted and have no effect.

Each pin is modelled as a separate input, output and output-enable signal, so the pad ring outside the block does the actual tri-stating.

Top module: `pp_parallel_port`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output enable is 0, every output pin is 0, `rd_data` is 0, and all four groups are inputs.
- R2: Address 0 selects port A, address 1 port B, address 2 port C and address 3 the control register.
- R3: A control write with bit 7 = 1 loads directions from bit 4 (port A), bit 1 (port B), bit 3 (C upper) and bit 0 (C lower), where 1 means input. From the next cycle on, every output enable of a group equals the inverse of its direction bit.
- R4: A control write with bit 7 = 0 changes no direction and no output enable.
- R5: Control bits 6, 5 and 2 (mode fields) have no effect. For example, 0xE4 gives the same directions as 0x80.
- R6: A write to address 0, 1 or 2 loads that port's output latch whatever its direction. The latch value appears on the port's output pins from the next cycle.
- R7: A read strobe registers the addressed value into `rd_data` one cycle later. A group set as output returns its latch, a group set as input returns its pins, and the two halves of port C are chosen independently. `rd_data` holds its value when there is no read strobe.
- R8: A read of address 3 returns {1, 0, 0, dirA, dirCupper, 0, dirB, dirClower} in bit order 7 down to 0.
- R9: Control byte 0x98 sets A input, B output, C upper input and C lower output. Control byte 0x8A sets A output, B input, C upper input and C lower output.
- R10: A read and a write to the same port in the same cycle return the latch value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | PORT_W | Write data |
| rd_data | output | PORT_W | Registered read data |
| pa_in | input | PORT_W | Port A pin inputs |
| pa_out | output | PORT_W | Port A output values |
| pa_oe | output | PORT_W | Port A output enables |
| pb_in | input | PORT_W | Port B pin inputs |
| pb_out | output | PORT_W | Port B output values |
| pb_oe | output | PORT_W | Port B output enables |
| pc_in | input | PORT_W | Port C pin inputs |
| pc_out | output | PORT_W | Port C output values |
| pc_oe | output | PORT_W | Port C output enables |

## Verification
On every cycle, the assertions check the following:
- latches are cleared after reset;
- a port write reaches the output pins;
- an unflagged control write leaves the directions unchanged;
- a flagged control write loads the direction bits;
- `rd_data` holds between reads.

Only the bench scenarios can show the following:
- the full read mux, with the port C halves split;
- the decoding of the two fixed control bytes;
- that mode bits are ignored;
- the read-before-write ordering.

The bench shows these by comparing all ports on every cycle against a behavioural model.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam logic [1:0] ADDR_A    = 2'd0;
  localparam logic [1:0] ADDR_B    = 2'd1;
  localparam logic [1:0] ADDR_C    = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  // control byte bit positions
  localparam int BIT_CL   = 0;
  localparam int BIT_B    = 1;
  localparam int BIT_CU   = 3;
  localparam int BIT_A    = 4;
  localparam int BIT_FLAG = 7;

  // 1 = group is input
  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } pp_dir_t;

  localparam pp_dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output pp_dir_t       dir,
  output logic [7:0]    image
);
  pp_dir_t dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RESET;
    end else if (wr_en && wr_data[BIT_FLAG]) begin
      dir_q.a_in  <= wr_data[BIT_A];
      dir_q.b_in  <= wr_data[BIT_B];
      dir_q.cu_in <= wr_data[BIT_CU];
      dir_q.cl_in <= wr_data[BIT_CL];
    end
  end

  assign dir = dir_q;

  always_comb begin
    image          = 8'h00;
    image[BIT_FLAG] = 1'b1;
    image[BIT_A]   = dir_q.a_in;
    image[BIT_B]   = dir_q.b_in;
    image[BIT_CU]  = dir_q.cu_in;
    image[BIT_CL]  = dir_q.cl_in;
  end

  // R4: unflagged control write keeps the directions
  a_r4_unflagged_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[BIT_FLAG]) |=> $stable(dir));

  // R3: flagged write loads the direction fields
  a_r3_dir_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[BIT_FLAG]) |=>
      (dir.a_in == $past(wr_data[BIT_A]) && dir.b_in == $past(wr_data[BIT_B]) &&
       dir.cu_in == $past(wr_data[BIT_CU]) && dir.cl_in == $past(wr_data[BIT_CL])));
endmodule

// File: rtl/pp_group.sv
module pp_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         dir_in,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst)        latch_q <= '0;
    else if (wr_en) latch_q <= wr_data;
  end

  assign pin_out = latch_q;
  assign pin_oe  = {W{~dir_in}};
  assign rd_val  = dir_in ? pin_in : latch_q;

  // R1: latch cleared coming out of reset
  a_r1_latch_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '0));

  // R6: port write is visible on the pins next cycle
  a_r6_latch_load: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (pin_out == $past(wr_data)));
endmodule

// File: rtl/pp_parallel_port.sv
module pp_parallel_port
  import pp_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] rd_data,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  localparam int HALF = PORT_W / 2;

  pp_dir_t          dir;
  logic [7:0]       ctrl_image;
  logic [PORT_W-1:0] a_rd, b_rd, c_rd;
  logic [PORT_W-1:0] rd_mux, rd_q;

  wire wr_a    = wr_en && (addr == ADDR_A);
  wire wr_b    = wr_en && (addr == ADDR_B);
  wire wr_c    = wr_en && (addr == ADDR_C);
  wire wr_ctrl = wr_en && (addr == ADDR_CTRL);

  pp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_ctrl), .wr_data(wr_data[7:0]),
    .dir(dir), .image(ctrl_image)
  );

  pp_group #(.W(PORT_W)) u_grp_a (
    .clk(clk), .rst(rst), .wr_en(wr_a), .wr_data(wr_data), .dir_in(dir.a_in),
    .pin_in(pa_in), .pin_out(pa_out), .pin_oe(pa_oe), .rd_val(a_rd)
  );

  pp_group #(.W(PORT_W)) u_grp_b (
    .clk(clk), .rst(rst), .wr_en(wr_b), .wr_data(wr_data), .dir_in(dir.b_in),
    .pin_in(pb_in), .pin_out(pb_out), .pin_oe(pb_oe), .rd_val(b_rd)
  );

  // port C: two halves, h=0 lower, h=1 upper
  for (genvar h = 0; h < 2; h++) begin : g_c_half
    logic half_dir;
    assign half_dir = (h == 1) ? dir.cu_in : dir.cl_in;
    pp_group #(.W(HALF)) u_grp_c (
      .clk(clk), .rst(rst), .wr_en(wr_c),
      .wr_data(wr_data[h*HALF +: HALF]), .dir_in(half_dir),
      .pin_in(pc_in[h*HALF +: HALF]), .pin_out(pc_out[h*HALF +: HALF]),
      .pin_oe(pc_oe[h*HALF +: HALF]), .rd_val(c_rd[h*HALF +: HALF])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_A:  rd_mux = a_rd;
      ADDR_B:  rd_mux = b_rd;
      ADDR_C:  rd_mux = c_rd;
      default: rd_mux[7:0] = ctrl_image;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;

  // R7: read data holds without a strobe
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R8: control read always shows the flag bit
  a_r8_ctrl_flag: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_CTRL) |=> rd_data[7]);
endmodule

// File: tb/tb_pp_parallel_port.sv
module tb_pp_parallel_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [W-1:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_parallel_port #(.PORT_W(W)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // reference model state
  logic [7:0] m_a, m_b, m_c, m_rd;
  bit m_da, m_db, m_dcu, m_dcl;
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  function automatic void chk(string tag, string nm, logic [7:0] got, logic [7:0] exp);
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s got %02h expected %02h", tag, nm, got, exp);
    end
  endfunction

  function automatic void compare_all(string tag);
    vectors++;
    chk(tag, "rd_data", rd_data, m_rd);
    chk(tag, "pa_out", pa_out, m_a);
    chk(tag, "pb_out", pb_out, m_b);
    chk(tag, "pc_out", pc_out, m_c);
    chk(tag, "pa_oe", pa_oe, {8{~m_da}});
    chk(tag, "pb_oe", pb_oe, {8{~m_db}});
    chk(tag, "pc_oe", pc_oe, {{4{~m_dcu}}, {4{~m_dcl}}});
  endfunction

  task automatic reset_vec(string tag);
    rst = 1'b1; wr_en = 0; rd_en = 0;
    m_a = 0; m_b = 0; m_c = 0; m_rd = 0;
    m_da = 1; m_db = 1; m_dcu = 1; m_dcl = 1;
    @(posedge clk); @(negedge clk);
    compare_all(tag);
  endtask

  task automatic vec(string tag, bit w, bit r, logic [1:0] a, logic [7:0] d);
    logic [7:0] v;
    rst = 1'b0; wr_en = w; rd_en = r; addr = a; wr_data = d;
    case (a)
      2'd0: v = m_da ? pa_in : m_a;
      2'd1: v = m_db ? pb_in : m_b;
      2'd2: v = {m_dcu ? pc_in[7:4] : m_c[7:4], m_dcl ? pc_in[3:0] : m_c[3:0]};
      default: v = {1'b1, 2'b00, m_da, m_dcu, 1'b0, m_db, m_dcl};
    endcase
    if (r) m_rd = v;
    if (w) begin
      case (a)
        2'd0: m_a = d;
        2'd1: m_b = d;
        2'd2: m_c = d;
        default: if (d[7]) begin
          m_da = d[4]; m_db = d[1]; m_dcu = d[3]; m_dcl = d[0];
        end
      endcase
    end
    @(posedge clk); @(negedge clk);
    compare_all(tag);
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    // R1 reset state, including first cycle after reset
    reset_vec("R1"); reset_vec("R1");
    vec("R1", 0, 0, 2'd0, 8'h00);

    // R2/R7 all inputs: reads return pins
    pa_in = 8'h11; pb_in = 8'h22; pc_in = 8'h33;
    vec("R2", 0, 1, 2'd0, 8'h00);
    vec("R2", 0, 1, 2'd1, 8'h00);
    vec("R2", 0, 1, 2'd2, 8'h00);
    vec("R8", 0, 1, 2'd3, 8'h00);

    // R6 latch loads while input
    vec("R6", 1, 0, 2'd0, 8'h5A);
    vec("R6", 1, 0, 2'd1, 8'hC3);
    vec("R6", 1, 0, 2'd2, 8'h96);

    // R9 0x98
    vec("R9", 1, 0, 2'd3, 8'h98);
    vec("R9", 0, 1, 2'd0, 8'h00);
    vec("R9", 0, 1, 2'd1, 8'h00);
    vec("R9", 0, 1, 2'd2, 8'h00);
    vec("R8", 0, 1, 2'd3, 8'h00);

    // R4 unflagged control write ignored
    vec("R4", 1, 0, 2'd3, 8'h7F);
    vec("R4", 0, 1, 2'd3, 8'h00);

    // R9 0x8A
    vec("R9", 1, 0, 2'd3, 8'h8A);
    pa_in = 8'hEE; pb_in = 8'h77; pc_in = 8'hA5;
    vec("R9", 0, 1, 2'd0, 8'h00);
    vec("R9", 0, 1, 2'd1, 8'h00);
    vec("R9", 0, 1, 2'd2, 8'h00);

    // R5 mode bits have no effect
    vec("R5", 1, 0, 2'd3, 8'hE4);
    vec("R5", 0, 1, 2'd3, 8'h00);
    vec("R5", 1, 0, 2'd3, 8'hFF);
    vec("R5", 0, 1, 2'd0, 8'h00);
    vec("R3", 1, 0, 2'd3, 8'h81);
    vec("R3", 0, 1, 2'd2, 8'h00);

    // R10 read and write same port together
    vec("R3", 1, 0, 2'd3, 8'h80);
    vec("R10", 1, 1, 2'd1, 8'h3C);
    vec("R10", 0, 1, 2'd1, 8'h00);
    vec("R10", 1, 1, 2'd2, 8'h0F);

    // R7 mixed traffic
    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pa_in = lf[7:0]; pb_in = lf[15:8]; pc_in = lf[11:4];
      vec("R7", lf[0], lf[1], lf[3:2], {lf[4], lf[13:7]});
    end

    // R1 reset mid-run clears everything
    reset_vec("R1");
    vec("R1", 0, 0, 2'd0, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule